// File: doc/BRIEF.md
# SPI host with configurable data FIFO

The block is an SPI host for one peripheral. Software reaches it through a small register interface with two addresses: a control/status word and a data word. Each write to the data word queues one byte for transmission. A shift engine sends each byte MSB first on the serial clock and data-out pins. At the same time it samples the data-in pin into a receive path, which software drains by reading the data word. Clock polarity, clock phase and the serial clock divider are set in the control word. The chip-select output comes only from a control bit.

The parameter `FIFO_DEPTH` sets the depth of the transmit and receive queues. The value 0 builds no queue. In that case the block behaves as a plain single-byte engine: a data write starts a transfer at once if the engine is idle, and the receive side is one holding register. Any non-zero depth must be a power of two. With queues built, the engine takes the next queued byte on the cycle after it finishes the current one. The busy flag then stays set until both the engine and the transmit queue are empty.

The interrupt output is a level signal. It is selected by a two-bit mode and gated by an enable bit. Mode 00 follows the engine being idle. Mode 10 follows an empty transmit queue. Mode 11 follows a transmit queue that is less than half full. Without a queue, the two queue modes cannot be stored and fall back to mode 00.

The shift engine is a three-state machine:
- IDLE moves to LEAD on a start request.
- LEAD moves to TRAIL when its half-bit timer ends, sampling the data-in pin at that point.
- TRAIL moves back to LEAD when its timer ends and bits remain, shifting the register at that point.
- TRAIL moves to IDLE when its timer ends on the last bit, pulsing done.

Top module: `spi_fifo_host`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sclk`, `spi_mosi` and `irq` are 0, and the control word holds only its read-only flags.
- R2: Each transfer moves 8 bits MSB first. Every half bit lasts DIV+1 clock cycles, where DIV is control bits [7:4]. The 16 serial clock edges of one byte span exactly 15*(DIV+1) cycles.
- R3: Control bit 1 (CPOL) is the idle level of `spi_sclk`. Control bit 2 (CPHA) chooses the edge on which data is valid. With CPHA 0 the peripheral samples on the edge leaving the idle level. With CPHA 1 it samples on the edge returning to it.
- R4: Reading the data address (addr 1) returns the oldest received byte in bits [7:0] and removes it. A read while nothing has been received returns 0.
- R5: While the transmit queue holds data, the next transfer starts on the cycle after the previous one finishes. The last edge of one byte and the first edge of the next are therefore DIV+2 cycles apart.
- R6: A data write while the transmit queue is full is dropped, and the queued bytes are sent unchanged.
- R7: Busy (status bit 16) is the engine's activity when FIFO_DEPTH is 0. With a queue it is the engine's activity OR a non-empty transmit queue.
- R8: Read-only status bits are: 17 TX empty, 18 TX at least half full, 19 TX full, 20 RX holds data, 21 RX full, and [27:24] log2 of FIFO_DEPTH (0 when there is no queue). With no queue, bit 17 reads 1, bit 18 reads 0 and bit 19 mirrors engine activity.
- R9: With interrupt mode 00 (control bits [9:8]) and interrupt enable (control bit 10) set, `irq` is high exactly while the shift engine is idle.
- R10: Mode 10 holds `irq` high while the TX queue is empty. Mode 11 holds it high while the TX queue holds fewer than FIFO_DEPTH/2 bytes. With control bit 10 clear, `irq` is 0.
- R11: With FIFO_DEPTH 0, a control write of mode 10 or 11 stores 00. Mode 01 is stored as written and acts like 00.
- R12: `spi_cs_n` is the inverse of control bit 3 and changes only on a control write, never during or between transfers.
- R13: With control bit 0 (enable) clear, no transfer starts, and queued bytes wait until it is set.
- R14: With FIFO_DEPTH 0, a data write while the engine is busy is dropped. A write while idle starts a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (pops RX on the data address) |
| bus_addr | input | 1 | 0 selects control/status, 1 selects data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected address, combinational |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to peripheral |
| spi_miso | input | 1 | Serial data from peripheral |
| spi_cs_n | output | 1 | Chip select, active low |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds two copies of the block. One uses FIFO_DEPTH 4: this small queue fills in four writes, which brings the full-drop, half-full and below-half conditions within reach in a few cycles. The other uses the default depth 0, which exercises the plain single-byte path and the interrupt-mode fallback. The depth-4 copy is swept over all four CPOL/CPHA combinations and divider values 0, 1 and 3. Three back-to-back bytes are sent in each case, and the bench computes the bit order, edge spacing and inter-byte gap from DIV.

// File: rtl/spi_fifo_pkg.sv
`timescale 1ns/1ps
package spi_fifo_pkg;

    localparam int CTRL_DIV_W = 4;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_LEAD  = 2'd1,
        ENG_TRAIL = 2'd2
    } eng_state_t;

    typedef enum logic [1:0] {
        IRQ_ENG_IDLE = 2'b00,
        IRQ_RESERVED = 2'b01,
        IRQ_TX_EMPTY = 2'b10,
        IRQ_TX_LOW   = 2'b11
    } irq_mode_t;

    typedef struct packed {
        logic                  irq_en;
        irq_mode_t             irq_mode;
        logic [CTRL_DIV_W-1:0] div;
        logic                  cs_on;
        logic                  cpha;
        logic                  cpol;
        logic                  en;
    } ctrl_t;

    localparam int CTRL_W     = $bits(ctrl_t);
    localparam int ST_BUSY    = 16;
    localparam int ST_TX_EMPT = 17;
    localparam int ST_TX_HALF = 18;
    localparam int ST_TX_FULL = 19;
    localparam int ST_RX_AVL  = 20;
    localparam int ST_RX_FULL = 21;
    localparam int ST_LOG2_LO = 24;
    localparam int ST_LOG2_W  = 4;

endpackage

// File: rtl/spi_word_fifo.sv
`timescale 1ns/1ps
module spi_word_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  logic [WIDTH-1:0]               wdata,
    input  logic                           pop,
    output logic [WIDTH-1:0]               rdata,
    output logic [$clog2(DEPTH+1)-1:0]     count,
    output logic                           empty,
    output logic                           full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem_q[rd_ptr_q];
    assign count   = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (do_push) wr_ptr_q <= ptr_next(wr_ptr_q);
            if (do_pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_ptr_q] <= wdata;
    end

    // R6: a push into a full queue leaves the queue untouched
    a_r6_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> ($stable(cnt_q) && $stable(wr_ptr_q)));

    // R8: occupancy never exceeds the depth
    a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));

endmodule

// File: rtl/spi_shift_engine.sv
`timescale 1ns/1ps
module spi_shift_engine
    import spi_fifo_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = CTRL_DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [DIV_W-1:0]  div,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_word
);
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    eng_state_t        state_q, state_d;
    logic [DIV_W-1:0]  tick_q;
    logic [BIT_W-1:0]  bit_q;
    logic [DATA_W-1:0] shreg_q;
    logic              samp_q;
    logic              half_end, last_bit;

    assign half_end = (tick_q == div);
    assign last_bit = (bit_q == BIT_W'(DATA_W - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ENG_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENG_IDLE:  if (start)    state_d = ENG_LEAD;
            ENG_LEAD:  if (half_end) state_d = ENG_TRAIL;
            ENG_TRAIL: if (half_end) state_d = last_bit ? ENG_IDLE : ENG_LEAD;
            default:                 state_d = ENG_IDLE;
        endcase
    end

    // datapath: half-bit timer, bit counter, shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q  <= '0;
            bit_q   <= '0;
            shreg_q <= '0;
            samp_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ENG_IDLE: begin
                    if (start) begin
                        shreg_q <= tx_word;
                        tick_q  <= '0;
                        bit_q   <= '0;
                    end
                end
                ENG_LEAD: begin
                    if (half_end) begin
                        samp_q <= miso;
                        tick_q <= '0;
                    end else begin
                        tick_q <= tick_q + 1'b1;
                    end
                end
                ENG_TRAIL: begin
                    if (half_end) begin
                        shreg_q <= {shreg_q[DATA_W-2:0], samp_q};
                        bit_q   <= bit_q + 1'b1;
                        tick_q  <= '0;
                    end else begin
                        tick_q <= tick_q + 1'b1;
                    end
                end
                default: tick_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy    = (state_q != ENG_IDLE);
        done    = (state_q == ENG_TRAIL) && half_end && last_bit;
        mosi    = busy ? shreg_q[DATA_W-1] : 1'b0;
        rx_word = {shreg_q[DATA_W-2:0], samp_q};
        if (!busy)     sclk = cpol;
        else if (cpha) sclk = cpol ^ (state_q == ENG_LEAD);
        else           sclk = cpol ^ (state_q == ENG_TRAIL);
    end

    // R2: an accepted start makes the engine active on the next cycle
    a_r2_start_goes_active: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R2: the finishing pulse always returns the engine to idle
    a_r2_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

// File: rtl/spi_fifo_host.sv
`timescale 1ns/1ps
module spi_fifo_host
    import spi_fifo_pkg::*;
#(
    parameter int FIFO_DEPTH = 0,
    parameter int DATA_W     = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic        bus_re,
    input  logic        bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic        spi_cs_n,
    output logic        irq
);
    localparam bit HAS_FIFO   = (FIFO_DEPTH > 0);
    localparam int LOG2_DEPTH = HAS_FIFO ? $clog2(FIFO_DEPTH) : 0;

    ctrl_t             ctrl_q, ctrl_new;
    logic              ctrl_wr, data_wr, data_rd;
    logic              eng_start, eng_busy, eng_done;
    logic [DATA_W-1:0] eng_tx, eng_rx;
    logic              tx_avail, tx_empty, tx_half, tx_full, tx_low;
    logic              rx_avail, rx_full;
    logic [DATA_W-1:0] rx_head;
    logic              busy, irq_cond;
    logic [31:CTRL_W]  unused_wdata_hi;

    assign unused_wdata_hi = bus_wdata[31:CTRL_W];
    assign ctrl_wr = bus_we && !bus_addr;
    assign data_wr = bus_we && bus_addr;
    assign data_rd = bus_re && bus_addr;

    // control word, with the mode fallback when no queue exists
    always_comb begin
        ctrl_new = ctrl_t'(bus_wdata[CTRL_W-1:0]);
        if (!HAS_FIFO && ctrl_new.irq_mode[1]) ctrl_new.irq_mode = IRQ_ENG_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= ctrl_new;
    end

    assign eng_start = ctrl_q.en && !eng_busy && tx_avail;

    spi_shift_engine #(.DATA_W(DATA_W), .DIV_W(CTRL_DIV_W)) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .cpol    (ctrl_q.cpol),
        .cpha    (ctrl_q.cpha),
        .div     (ctrl_q.div),
        .start   (eng_start),
        .tx_word (eng_tx),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .busy    (eng_busy),
        .done    (eng_done),
        .rx_word (eng_rx)
    );

    generate
        if (HAS_FIFO) begin : g_queue
            localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
            localparam int HALF  = FIFO_DEPTH / 2;
            logic [CNT_W-1:0] tx_count;
            logic [CNT_W-1:0] unused_rx_count;

            spi_word_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
                .clk   (clk),
                .rst_n (rst_n),
                .push  (data_wr),
                .wdata (bus_wdata[DATA_W-1:0]),
                .pop   (eng_start),
                .rdata (eng_tx),
                .count (tx_count),
                .empty (tx_empty),
                .full  (tx_full)
            );

            logic rx_empty;
            spi_word_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
                .clk   (clk),
                .rst_n (rst_n),
                .push  (eng_done),
                .wdata (eng_rx),
                .pop   (data_rd),
                .rdata (rx_head),
                .count (unused_rx_count),
                .empty (rx_empty),
                .full  (rx_full)
            );

            assign rx_avail = !rx_empty;
            assign tx_avail = !tx_empty;
            assign tx_half  = (tx_count >= CNT_W'(HALF));
            assign tx_low   = (tx_count <  CNT_W'(HALF));
            assign busy     = eng_busy || !tx_empty;

            // R5: queued data with an idle, enabled engine starts a transfer next cycle
            a_r5_queue_feeds_engine: assert property (@(posedge clk) disable iff (!rst_n)
                (ctrl_q.en && !tx_empty && !eng_busy) |=> eng_busy);
        end else begin : g_direct
            logic              hold_vld_q;
            logic [DATA_W-1:0] hold_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    hold_vld_q <= 1'b0;
                    hold_q     <= '0;
                end else if (eng_done) begin
                    hold_vld_q <= 1'b1;
                    hold_q     <= eng_rx;
                end else if (data_rd) begin
                    hold_vld_q <= 1'b0;
                end
            end

            assign eng_tx   = bus_wdata[DATA_W-1:0];
            assign tx_avail = data_wr;
            assign tx_empty = 1'b1;
            assign tx_half  = 1'b0;
            assign tx_full  = eng_busy;
            assign tx_low   = 1'b0;
            assign rx_avail = hold_vld_q;
            assign rx_full  = hold_vld_q;
            assign rx_head  = hold_q;
            assign busy     = eng_busy;

            // R11: without a queue the stored mode never selects a queue condition
            a_r11_mode_fallback: assert property (@(posedge clk) disable iff (!rst_n)
                !ctrl_q.irq_mode[1]);
        end
    endgenerate

    always_comb begin
        unique case (ctrl_q.irq_mode)
            IRQ_TX_EMPTY: irq_cond = tx_empty;
            IRQ_TX_LOW:   irq_cond = tx_low;
            default:      irq_cond = !eng_busy;
        endcase
    end

    assign irq      = ctrl_q.irq_en && irq_cond;
    assign spi_cs_n = !ctrl_q.cs_on;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr) begin
            if (rx_avail) bus_rdata[DATA_W-1:0] = rx_head;
        end else begin
            bus_rdata[CTRL_W-1:0] = ctrl_q;
            bus_rdata[ST_BUSY]    = busy;
            bus_rdata[ST_TX_EMPT] = tx_empty;
            bus_rdata[ST_TX_HALF] = tx_half;
            bus_rdata[ST_TX_FULL] = tx_full;
            bus_rdata[ST_RX_AVL]  = rx_avail;
            bus_rdata[ST_RX_FULL] = rx_full;
            bus_rdata[ST_LOG2_LO +: ST_LOG2_W] = ST_LOG2_W'(LOG2_DEPTH);
        end
    end

    // R12: chip select moves only on a control write
    a_r12_cs_software_only: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(spi_cs_n));

    // R13: a disabled block never launches the engine
    a_r13_disabled_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.en && !eng_busy) |=> !eng_busy);

endmodule

// File: tb/test_spi_fifo_host.sv
`timescale 1ns/1ps
module test_spi_fifo_host;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        we_a = 0, re_a = 0, addr_a = 0;
    logic [31:0] wdata_a = 0, rdata_a;
    logic        sclk_a, mosi_a, miso_a, csn_a, irq_a;
    logic        we_b = 0, re_b = 0, addr_b = 0;
    logic [31:0] wdata_b = 0, rdata_b;
    logic        sclk_b, mosi_b, miso_b, csn_b, irq_b;

    assign miso_a = ~mosi_a;
    assign miso_b = ~mosi_b;

    spi_fifo_host #(.FIFO_DEPTH(DEPTH)) i_spi_fifo_host (
        .clk(clk), .rst_n(rst_n), .bus_we(we_a), .bus_re(re_a), .bus_addr(addr_a),
        .bus_wdata(wdata_a), .bus_rdata(rdata_a), .spi_sclk(sclk_a), .spi_mosi(mosi_a),
        .spi_miso(miso_a), .spi_cs_n(csn_a), .irq(irq_a));

    spi_fifo_host i_spi_fifo_host_bare (
        .clk(clk), .rst_n(rst_n), .bus_we(we_b), .bus_re(re_b), .bus_addr(addr_b),
        .bus_wdata(wdata_b), .bus_rdata(rdata_b), .spi_sclk(sclk_b), .spi_mosi(mosi_b),
        .spi_miso(miso_b), .spi_cs_n(csn_b), .irq(irq_b));

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit finished = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cw(input bit en, input bit cpol, input bit cpha, input bit cs,
                                       input int div, input int mode, input bit ie);
        return {21'b0, ie, mode[1:0], div[3:0], cs, cpha, cpol, en};
    endfunction

    task automatic wr(input bit sel, input bit a, input logic [31:0] d);
        @(negedge clk);
        if (sel) begin we_b = 1; addr_b = a; wdata_b = d; end
        else     begin we_a = 1; addr_a = a; wdata_a = d; end
        @(negedge clk);
        we_a = 0; we_b = 0;
    endtask

    task automatic rd(input bit sel, input bit a, output logic [31:0] v);
        @(negedge clk);
        if (sel) begin addr_b = a; re_b = 1; #1 v = rdata_b; end
        else     begin addr_a = a; re_a = 1; #1 v = rdata_a; end
        @(negedge clk);
        re_a = 0; re_b = 0;
    endtask

    task automatic wait_idle(input bit sel, input string req);
        logic [31:0] v;
        for (int k = 0; k < 4000; k++) begin
            rd(sel, 0, v);
            if (!v[16]) return;
        end
        check(req, 32'd1, 32'd0);
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // serial monitor for the queued instance
    bit          mon_on = 0, exp_cpol = 0, exp_cpha = 0, cs_bad = 0;
    logic        prev_sclk = 0;
    int          tog = 0, nb = 0;
    logic [7:0]  cap = 0;
    logic [7:0]  obs [16];
    int          first_t [16], last_t [16];

    always @(negedge clk) begin
        if (mon_on && sclk_a !== prev_sclk) begin
            if (csn_a !== 1'b0) cs_bad = 1;
            if (tog == 0) begin cap = 0; if (nb < 16) first_t[nb] = cyc; end
            if ((sclk_a != exp_cpol) == !exp_cpha) cap = {cap[6:0], mosi_a};
            if (tog == 15) begin
                if (nb < 16) begin last_t[nb] = cyc; obs[nb] = cap; end
                nb++;
                tog = 0;
            end else tog++;
        end
        prev_sclk = sclk_a;
    end

    task automatic mon_arm(input bit cpol, input bit cpha);
        mon_on = 0;
        exp_cpol = cpol; exp_cpha = cpha;
        wait_cycles(2);
        tog = 0; nb = 0; cs_bad = 0;
        mon_on = 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  bytes [4];
        wait_cycles(3);
        rst_n = 1;
        wait_cycles(1);

        // R1 / R8 reset state
        check("R1 cs_n a", csn_a, 1); check("R1 sclk a", sclk_a, 0);
        check("R1 mosi a", mosi_a, 0); check("R1 irq a", irq_a, 0);
        check("R1 cs_n b", csn_b, 1); check("R1 irq b", irq_b, 0);
        rd(0, 0, v); check("R1 R8 ctrl depth4", v, 32'h0202_0000);
        rd(1, 0, v); check("R1 R8 ctrl depth0", v, 32'h0002_0000);
        rd(0, 1, v); check("R4 empty rx read", v, 0);

        // R2 R3 R5 R12 R4: sweep modes and dividers
        for (int m = 0; m < 4; m++) begin
            for (int di = 0; di < 3; di++) begin
                int d;
                int dd;
                d  = (di == 2) ? 3 : di;
                dd = d + 1;
                mon_on = 0;
                wr(0, 0, cw(1, m[1], m[0], 1, d, 0, 0));
                mon_arm(m[1], m[0]);
                for (int i = 0; i < 3; i++) begin
                    bytes[i] = 8'((m * 53 + d * 29 + i * 71 + 17) & 255);
                    wr(0, 1, {24'b0, bytes[i]});
                end
                wait_idle(0, "R7 sweep idle");
                wait_cycles(2);
                check("R2 byte count", nb, 3);
                for (int i = 0; i < 3; i++) begin
                    check("R2 R3 mosi byte", obs[i], bytes[i]);
                    check("R2 edge span", last_t[i] - first_t[i], 15 * dd);
                    if (i > 0) check("R5 back-to-back gap", first_t[i] - last_t[i-1], dd + 1);
                end
                check("R3 idle sclk level", sclk_a, m[1]);
                check("R12 cs_n held", {cs_bad, csn_a}, 0);
                for (int i = 0; i < 3; i++) begin
                    rd(0, 1, v); check("R4 rx byte", v, {24'b0, ~bytes[i]});
                end
                rd(0, 1, v); check("R4 rx drained", v, 0);
                mon_on = 0;
            end
        end

        // R13 R6 R7 R8 R9: queue while disabled
        wr(0, 0, cw(0, 0, 0, 1, 0, 0, 0));
        mon_arm(0, 0);
        for (int i = 0; i < 4; i++) wr(0, 1, 32'hC0 + i);
        wait_cycles(4);
        check("R13 no edges while disabled", tog + nb, 0);
        rd(0, 0, v);
        check("R7 busy with queued data", v[16], 1);
        check("R8 tx flags full", v[19:17], 3'b110);
        wr(0, 1, 32'hEE);
        wr(0, 0, cw(0, 0, 0, 1, 0, 2, 1)); check("R10 mode10 queue nonempty", irq_a, 0);
        wr(0, 0, cw(0, 0, 0, 1, 0, 3, 1)); check("R10 mode11 queue full", irq_a, 0);
        wr(0, 0, cw(0, 0, 0, 1, 0, 0, 1)); check("R9 idle engine irq", irq_a, 1);
        wr(0, 0, cw(1, 0, 0, 1, 0, 0, 1));
        wait_cycles(2);
        check("R9 irq low while shifting", irq_a, 0);
        wait_idle(0, "R13 idle");
        wait_cycles(2);
        check("R6 R13 sent count", nb, 4);
        for (int i = 0; i < 4; i++) check("R6 queued bytes intact", obs[i], 32'hC0 + i);
        check("R9 irq back high", irq_a, 1);
        rd(0, 0, v); check("R8 rx full flags", v[21:20], 2'b11);
        for (int i = 0; i < 4; i++) begin
            rd(0, 1, v); check("R4 rx after queue", v, {24'b0, ~(8'hC0 + 8'(i))});
        end
        rd(0, 1, v); check("R4 rx empty again", v, 0);
        mon_on = 0;

        // R10 R8: below-half and empty modes
        wr(0, 0, cw(0, 0, 0, 1, 0, 3, 1));
        check("R10 mode11 empty queue", irq_a, 1);
        wr(0, 1, 32'h11);
        check("R10 mode11 one queued", irq_a, 1);
        rd(0, 0, v); check("R8 half flag one queued", v[18], 0);
        wr(0, 1, 32'h22);
        check("R10 mode11 two queued", irq_a, 0);
        rd(0, 0, v); check("R8 half flag two queued", v[18], 1);
        wr(0, 0, cw(0, 0, 0, 1, 0, 2, 1));
        check("R10 mode10 two queued", irq_a, 0);
        wr(0, 0, cw(1, 0, 0, 1, 0, 2, 1));
        wait_idle(0, "R10 idle");
        check("R10 mode10 drained", irq_a, 1);
        rd(0, 1, v); check("R4 rx 0x11", v, 32'hEE);
        rd(0, 1, v); check("R4 rx 0x22", v, 32'hDD);

        // R10 R7: empty queue while the last byte still shifts
        wr(0, 1, 32'h96);
        wait_cycles(2);
        check("R10 mode10 high during last byte", irq_a, 1);
        rd(0, 0, v); check("R7 busy during last byte", v[17:16], 2'b11);
        wait_idle(0, "R7 idle");
        rd(0, 1, v); check("R4 rx 0x96", v, 32'h69);
        wr(0, 0, cw(1, 0, 0, 1, 0, 2, 0));
        check("R10 irq disabled", irq_a, 0);

        // R11: fallback without queue
        wr(1, 0, cw(0, 0, 0, 0, 0, 3, 1)); rd(1, 0, v); check("R11 mode11 stored", v[9:8], 0);
        wr(1, 0, cw(0, 0, 0, 0, 0, 2, 1)); rd(1, 0, v); check("R11 mode10 stored", v[9:8], 0);
        wr(1, 0, cw(0, 0, 0, 0, 0, 1, 1)); rd(1, 0, v); check("R11 mode01 stored", v[9:8], 1);
        check("R11 mode01 acts as idle irq", irq_b, 1);

        // R14 R7 R8 R9: single-byte path
        wr(1, 0, cw(1, 0, 0, 1, 1, 0, 1));
        check("R12 cs_n follows bit3", csn_b, 0);
        wr(1, 1, 32'h5A);
        wr(1, 1, 32'hC3);
        rd(1, 0, v); check("R7 R8 depth0 busy flags", v[19:16], 4'b1011);
        check("R9 depth0 irq while busy", irq_b, 0);
        wait_idle(1, "R14 idle");
        check("R9 depth0 irq idle", irq_b, 1);
        rd(1, 0, v); check("R8 depth0 rx flags", v[21:20], 2'b11);
        rd(1, 1, v); check("R14 R4 first byte only", v, 32'hA5);
        rd(1, 1, v); check("R14 R4 second write dropped", v, 0);
        wr(1, 1, 32'h3C);
        wait_idle(1, "R14 idle 2");
        rd(1, 1, v); check("R14 idle write accepted", v, 32'hC3);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule